// File: doc/BRIEF.md
# Modem Control and Status Loopback Unit

This unit holds the modem control register and the modem status register of a 16550-style serial port whose modem lines are not wired to pins. Software writes the control register over a small register bus. The unit turns the control value into four line states: clear-to-send, data-set-ready, ring indicator and carrier detect. In loopback mode each line follows one control bit. Outside loopback the lines sit at a fixed idle level, with carrier detect and data-set-ready asserted and the other two deasserted.

Each control write is compared with the line states it replaces. A change sets a sticky delta bit in the low nibble of the status register. The ring line is the exception: its delta bit sets only on a falling edge. Reading the status register returns its value and clears the delta bits in the same access. A registered "delta pending" flag goes to the port's interrupt logic.

Top module: `modem_line_status`

## Requirements
- R1: After a synchronous reset the control register reads 0x00, the status register reads 0xA0 and `delta_pend` is 0.
- R2: A write to the control address (default 4) stores only bits 0 to 4 of `wdata`. Bits 5 to 7 of the control register always read 0.
- R3: When control bit 4 (loopback) is set, the status bits follow the control bits. Status bit 4 (clear-to-send) copies control bit 1, bit 5 (data-set-ready) copies bit 0, bit 6 (ring) copies bit 2, and bit 7 (carrier detect) copies bit 3.
- R4: When control bit 4 is clear, status bits 7 to 4 read 4'b1010.
- R5: A control write that changes clear-to-send, data-set-ready or carrier detect sets status bit 0, 1 or 3 respectively.
- R6: Status bit 2 (ring delta) sets only when the ring line goes from 1 to 0. A rising ring line leaves it unchanged.
- R7: Delta bits stay set through later control writes until the status register is read.
- R8: A read of the status address (default 6) returns the status value from before the access and clears bits 0 to 3. Bits 7 to 4 are not changed by the read.
- R9: Writes to the status address change no state.
- R10: `delta_pend` is 1 exactly when any of status bits 0 to 3 is set, and it updates on the same edge as the status register.
- R11: `rdata` is registered. It carries the read result on the clock edge that samples `rd_en`, and holds its value on cycles with no read. A read of any address other than the control or status address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| mcr_out | output | 8 | Current control register value |
| msr_out | output | 8 | Current status register value (line states high, deltas low) |
| delta_pend | output | 1 | Any delta bit set |

## Verification
Every result is due one clock edge after the strobe that causes it. The edge that samples a control write also updates `mcr_out`, the line states in `msr_out`, the delta bits and `delta_pend`. The edge that samples a read loads `rdata` and applies the status clear. The bench changes inputs on the falling edge and compares all outputs with its model one time unit after the next rising edge, so each comparison sees exactly one new edge's worth of effect.

// File: rtl/modem_line_pkg.sv
package modem_line_pkg;
  localparam int NUM_LINES = 4;
  localparam int MCR_BITS  = 5;

  // control register bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;

  // line indices (also delta bit positions)
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  typedef logic [NUM_LINES-1:0] line_vec_t;

  // carrier detect and data-set-ready held high outside loopback
  localparam line_vec_t IDLE_LINES = 4'b1010;
endpackage

// File: rtl/mcr_reg.sv
module mcr_reg
  import modem_line_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [7:0]          wdata,
  output logic [MCR_BITS-1:0] mcr_q
);
  always_ff @(posedge clk) begin
    if (rst)     mcr_q <= '0;
    else if (we) mcr_q <= wdata[MCR_BITS-1:0];
  end

  p_mcr_keep_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> (mcr_q == $past(wdata[MCR_BITS-1:0])));
endmodule

// File: rtl/line_mapper.sv
module line_mapper
  import modem_line_pkg::*;
(
  input  logic [MCR_BITS-1:0] mcr_val,
  output line_vec_t           lines
);
  line_vec_t loop_lines;

  always_comb begin
    loop_lines        = '0;
    loop_lines[L_CTS] = mcr_val[C_RTS];
    loop_lines[L_DSR] = mcr_val[C_DTR];
    loop_lines[L_RI]  = mcr_val[C_OUT1];
    loop_lines[L_DCD] = mcr_val[C_OUT2];
    lines = mcr_val[C_LOOP] ? loop_lines : IDLE_LINES;
  end
endmodule

// File: rtl/delta_tracker.sv
module delta_tracker
  import modem_line_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      upd,
  input  line_vec_t old_lines,
  input  line_vec_t new_lines,
  input  logic      clr,
  output line_vec_t delta_q,
  output logic      pend_q
);
  line_vec_t hit;
  line_vec_t d_nxt;

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    if (gi == L_RI) begin : g_trail
      assign hit[gi] = upd & old_lines[gi] & ~new_lines[gi];
    end else begin : g_any
      assign hit[gi] = upd & (old_lines[gi] ^ new_lines[gi]);
    end
  end

  assign d_nxt = (clr ? '0 : delta_q) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      delta_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      delta_q <= d_nxt;
      pend_q  <= |d_nxt;
    end
  end

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
endmodule

// File: rtl/modem_line_status.sv
module modem_line_status
  import modem_line_pkg::*;
#(
  parameter int                ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] MCR_ADDR = ADDR_W'(4),
  parameter logic [ADDR_W-1:0] MSR_ADDR = ADDR_W'(6)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [7:0]        mcr_out,
  output logic [7:0]        msr_out,
  output logic              delta_pend
);
  localparam int PAD_W = 8 - MCR_BITS;

  logic                mcr_we;
  logic                msr_rd;
  logic [MCR_BITS-1:0] mcr_q;
  line_vec_t           lines_q;
  line_vec_t           lines_nxt;
  line_vec_t           delta_q;

  assign mcr_we = wr_en && (addr == MCR_ADDR);
  assign msr_rd = rd_en && (addr == MSR_ADDR);

  mcr_reg u_mcr (
    .clk   (clk),
    .rst   (rst),
    .we    (mcr_we),
    .wdata (wdata),
    .mcr_q (mcr_q)
  );

  line_mapper u_map (
    .mcr_val (wdata[MCR_BITS-1:0]),
    .lines   (lines_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)         lines_q <= IDLE_LINES;
    else if (mcr_we) lines_q <= lines_nxt;
  end

  delta_tracker u_delta (
    .clk       (clk),
    .rst       (rst),
    .upd       (mcr_we),
    .old_lines (lines_q),
    .new_lines (lines_nxt),
    .clr       (msr_rd),
    .delta_q   (delta_q),
    .pend_q    (delta_pend)
  );

  assign mcr_out = {{PAD_W{1'b0}}, mcr_q};
  assign msr_out = {lines_q, delta_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == MCR_ADDR)      rdata <= mcr_out;
      else if (addr == MSR_ADDR) rdata <= msr_out;
      else                       rdata <= '0;
    end
  end

  p_pend_r10: assert property (@(posedge clk) disable iff (rst)
    delta_pend == (msr_out[3:0] != 4'h0));
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    msr_rd |=> (msr_out[3:0] == 4'h0) && (msr_out[7:4] == $past(msr_out[7:4])));
  p_msr_wr_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == MSR_ADDR && !rd_en) |=> $stable(msr_out));
  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !mcr_out[4] |-> (msr_out[7:4] == 4'b1010));
  p_loop_r3: assert property (@(posedge clk) disable iff (rst)
    mcr_out[4] |-> (msr_out[7:4] == {mcr_out[3], mcr_out[2], mcr_out[0], mcr_out[1]}));
  p_ring_edge_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(msr_out[2]) |-> ($past(msr_out[6]) && !msr_out[6]));
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    mcr_out[7:5] == 3'b000);
endmodule

// File: tb/modem_line_status_bench.sv
module modem_line_status_bench;
  localparam int ADDR_W = 3;
  localparam logic [2:0] A_MCR = 3'd4;
  localparam logic [2:0] A_MSR = 3'd6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, mcr_out, msr_out;
  logic delta_pend;

  always #4 clk = ~clk;  // 125 MHz

  modem_line_status u_modem_line_status (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mcr_out(mcr_out), .msr_out(msr_out),
    .delta_pend(delta_pend)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [4:0] m_mcr;
  logic [3:0] m_lines, m_delta;
  logic [7:0] m_rdata;

  function automatic logic [3:0] map_lines(input logic [4:0] c);
    if (c[4]) return {c[3], c[2], c[0], c[1]};
    return 4'b1010;
  endfunction

  function automatic logic [3:0] delta_hits(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] h;
    h = o ^ n;
    h[2] = o[2] & ~n[2];
    return h;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d);
    logic [3:0] nl, hits;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    hits = 4'h0; nl = m_lines;
    if (r) begin
      if (a == A_MCR)      m_rdata = {3'b000, m_mcr};
      else if (a == A_MSR) m_rdata = {m_lines, m_delta};
      else                 m_rdata = 8'h00;
    end
    if (w && a == A_MCR) begin
      nl = map_lines(d[4:0]);
      hits = delta_hits(m_lines, nl);
      m_mcr = d[4:0];
    end
    m_delta = ((r && a == A_MSR) ? 4'h0 : m_delta) | hits;
    m_lines = nl;
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0;
    check("R2 mcr", mcr_out, {3'b000, m_mcr});
    check("R3/R4/R5/R6/R7 msr", msr_out, {m_lines, m_delta});
    check("R10 pend", {7'd0, delta_pend}, {7'd0, |m_delta});
    if (r) check("R11/R8 rdata", rdata, m_rdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    m_mcr = 0; m_lines = 4'b1010; m_delta = 0; m_rdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    check("R1 mcr", mcr_out, 8'h00);
    check("R1 msr", msr_out, 8'hA0);
    check("R1 pend", {7'd0, delta_pend}, 8'h00);
    // R2 upper bits dropped
    step(1, 0, A_MCR, 8'hE0);
    check("R2 upper bits", mcr_out, 8'h00);
    // R4 idle levels, R5 loopback all low: DSR and DCD drop
    step(1, 0, A_MCR, 8'h10);
    check("R5 dsr/dcd delta", msr_out, 8'h0A);
    // R7 sticky across another write
    step(1, 0, A_MCR, 8'h12);
    check("R7 sticky + R5 cts", msr_out, 8'h1B);
    // R9 MSR write ignored
    step(1, 0, A_MSR, 8'h00);
    check("R9 msr write", msr_out, 8'h1B);
    // R8 read returns pre-clear value and clears deltas
    step(0, 1, A_MSR, 8'h00);
    check("R8 read value", rdata, 8'h1B);
    check("R8 cleared", msr_out, 8'h10);
    // R6 rising ring sets no delta, falling does
    step(1, 0, A_MCR, 8'h16);
    check("R6 ring rise", msr_out, 8'h50);
    step(1, 0, A_MCR, 8'h12);
    check("R6 ring fall", msr_out, 8'h14);
    // R3 all lines high in loopback
    step(1, 0, A_MCR, 8'h1F);
    check("R3 loop map", msr_out[7:4], 8'h0F);
    // R4 back to idle
    step(1, 0, A_MCR, 8'h00);
    check("R4 idle", msr_out[7:4], 8'h0A);
    // R11 unmapped read returns 0
    step(0, 1, 3'd2, 8'h00);
    check("R11 unmapped", rdata, 8'h00);
    step(0, 1, A_MCR, 8'h00);
    check("R11 mcr readback", rdata, 8'h00);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 5) ? A_MCR : (sel < 8) ? A_MSR : 3'($urandom_range(0, 7));
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, 8'($urandom()));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule